// File: doc/BRIEF.md
# Pipelined Multiply/Divide Sequencer

This block is the 16-bit unsigned multiply and divide engine of a four-stage instruction pipeline. The clock is one machine cycle, which equals two state times or four oscillator periods. A multiply occupies five machine cycles and a divide ten. The pipeline is never frozen while the engine works. The first cycle of an operation is its normal issue slot. For each further cycle the engine asks the decode stage to insert a dummy instruction, which then travels down the later stages as a NOP.

An operation starts on a single-cycle strobe that also carries the opcode select and the two operand words. While the engine runs it raises a busy flag and the bubble request. When it finishes it gives a one-cycle done pulse and registers the result. A multiply yields the 32-bit product as a high word and a low word. A divide yields the quotient in the low word and the remainder in the high word. A pending interrupt can cancel a running operation through the abort input. The engine then discards its partial work and is free on the next cycle, so the interrupt vector is taken without waiting for the arithmetic.

Top module: `mulDivSeq`

## Requirements
- R1: After reset, busyOut, bubbleOut, doneOut and divErr are 0 and resHi and resLo are all zeros.
- R2: A start taken with opDiv=0 (multiply) holds busyOut high for the 4 cycles after the accepting edge. doneOut is high for exactly one cycle, the 5th cycle after that edge.
- R3: A start taken with opDiv=1 (divide) holds busyOut high for the 9 cycles after the accepting edge. doneOut is high for exactly one cycle, the 10th cycle after that edge.
- R4: bubbleOut is high in every cycle where busyOut is high and abortIn is low. It is low whenever abortIn is high or the engine is idle.
- R5: When a multiply is done, {resHi, resLo} equals the unsigned product opA*opB, with resHi as bits 31..16. divErr is 0.
- R6: When a divide is done with a nonzero divisor, resLo equals the unsigned quotient opA/opB and resHi equals the remainder opA%opB, which is below opB. divErr is 0.
- R7: When a divide is done with opB zero, divErr is 1, resLo is 16'hFFFF and resHi equals the dividend opA.
- R8: If abortIn is high during a busy cycle, busyOut is low from the next cycle. No done pulse follows for that operation, and resHi, resLo and divErr keep the values they had before the aborted start.
- R9: A start strobe that arrives while busyOut is high is ignored. The running operation keeps its opcode, operands and timing, and no second operation follows it.
- R10: abortIn asserted while the engine is idle changes no output.
- R11: resHi, resLo and divErr change only on the edge that raises doneOut and hold their value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, taken only while idle |
| opDiv | input | 1 | Operation select: 0 multiply, 1 divide |
| opA | input | 16 | Multiplicand or dividend |
| opB | input | 16 | Multiplier or divisor |
| abortIn | input | 1 | Interrupt request that cancels a running operation |
| busyOut | output | 1 | Operation in progress |
| bubbleOut | output | 1 | Request to insert a dummy instruction at decode this cycle |
| doneOut | output | 1 | One-cycle pulse when a result is committed |
| resHi | output | 16 | Product high word or remainder |
| resLo | output | 16 | Product low word or quotient |
| divErr | output | 1 | Divide by zero on the last committed divide |

## Verification
If the cycle counter is off by one, doneOut and the fall of busyOut move by a cycle. The bubble count then no longer matches the 4 or 9 that decode expects, and this is visible in the first operation after reset. A wrong step count or a bad partial remainder inside the iterative datapath shows up as a wrong product or quotient at the done pulse of that same operation. Operand pairs near the word limits, such as all-ones times all-ones or a divisor of one, expose it at once. State that an abort fails to clear shows up as a late done pulse or as result words that change after the abort. A start that is wrongly latched while busy shows up as a second done pulse after the first one.

// File: rtl/mds_pkg.sv
package mds_pkg;

  // Strobes from the sequencer control to the arithmetic datapath.
  typedef struct packed {
    logic load;    // capture operands, clear work registers
    logic step;    // advance the iteration by one cycle's worth of bits
    logic finish;  // commit the next-state result to the output words
    logic isDiv;   // operation under way (or being loaded) is a divide
  } mdsStrobe_t;

endpackage

// File: rtl/mds_ctrl.sv
module mds_ctrl #(
  parameter int MUL_CYC = 5,
  parameter int DIV_CYC = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic               opDiv,
  input  logic               abortIn,
  output logic               busyOut,
  output logic               bubbleOut,
  output logic               doneOut,
  output mds_pkg::mdsStrobe_t stb
);

  localparam int MAXC = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic          busyQ;
  logic          doneQ;
  logic          opQ;
  logic [CW-1:0] cntQ;
  logic          accept;
  logic          lastCyc;

  assign accept  = startIn & ~busyQ;
  assign lastCyc = busyQ & ~abortIn & (cntQ == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      opQ   <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= lastCyc;
      if (accept) begin
        busyQ <= 1'b1;
        opQ   <= opDiv;
        cntQ  <= opDiv ? CW'(DIV_CYC - 1) : CW'(MUL_CYC - 1);
      end else if (busyQ) begin
        if (abortIn || lastCyc) begin
          busyQ <= 1'b0;
        end else begin
          cntQ <= cntQ - CW'(1);
        end
      end
    end
  end

  always_comb begin
    stb.load   = accept;
    stb.step   = busyQ & ~abortIn;
    stb.finish = lastCyc;
    stb.isDiv  = accept ? opDiv : opQ;
  end

  assign busyOut   = busyQ;
  assign bubbleOut = busyQ & ~abortIn;
  assign doneOut   = doneQ;

  // R2, R3: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8: abort during a busy cycle frees the engine and suppresses done
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && abortIn) |=> (!busyQ && !doneQ));

  // R3: busy ends without abort only by completing
  assert_fall_means_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !abortIn) |=> (busyQ || doneQ));

  // R9: a start while busy neither restarts nor changes the opcode
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startIn && !abortIn && cntQ != CW'(1)) |=> (busyQ && $stable(opQ)));

  // R4: a bubble is never requested in an abort cycle
  assert_no_bubble_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |-> !bubbleOut);

endmodule

// File: rtl/mds_dp.sv
module mds_dp #(
  parameter int WIDTH   = 16,
  parameter int MUL_CYC = 5,
  parameter int DIV_CYC = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  mds_pkg::mdsStrobe_t stb,
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  output logic [WIDTH-1:0]    resHi,
  output logic [WIDTH-1:0]    resLo,
  output logic                divErr
);

  // Bits retired per cycle, sized so the iteration fits the cycle budget.
  localparam int MB = (WIDTH + MUL_CYC - 2) / (MUL_CYC - 1);
  localparam int DB = (WIDTH + DIV_CYC - 2) / (DIV_CYC - 1);
  localparam int BW = $clog2(WIDTH + 1);
  localparam int PW = 2 * WIDTH;

  // multiply work state
  logic [PW-1:0]    accQ, mcQ;
  logic [WIDTH-1:0] mpQ;
  logic [PW-1:0]    accN, mcN;
  logic [WIDTH-1:0] mpN;

  // divide work state
  logic [WIDTH-1:0] remQ, quoQ, dvsQ, dendQ;
  logic [BW-1:0]    leftQ;
  logic [WIDTH-1:0] remN, quoN;
  logic [BW-1:0]    leftN;
  logic [WIDTH:0]   trial;
  logic             qBit;

  // shift-and-add multiply, MB bits per cycle
  always_comb begin
    accN = accQ;
    mcN  = mcQ;
    mpN  = mpQ;
    for (int j = 0; j < MB; j++) begin
      if (mpN[0]) accN = accN + mcN;
      mcN = mcN << 1;
      mpN = mpN >> 1;
    end
  end

  // restoring divide, DB bits per cycle, stops after WIDTH bits
  always_comb begin
    remN  = remQ;
    quoN  = quoQ;
    leftN = leftQ;
    trial = '0;
    qBit  = 1'b0;
    for (int j = 0; j < DB; j++) begin
      if (leftN != '0) begin
        trial = {remN, quoN[WIDTH-1]};
        if (trial >= {1'b0, dvsQ}) begin
          trial = trial - {1'b0, dvsQ};
          qBit  = 1'b1;
        end else begin
          qBit  = 1'b0;
        end
        remN  = trial[WIDTH-1:0];
        quoN  = {quoN[WIDTH-2:0], qBit};
        leftN = leftN - BW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      mcQ   <= '0;
      mpQ   <= '0;
      remQ  <= '0;
      quoQ  <= '0;
      dvsQ  <= '0;
      dendQ <= '0;
      leftQ <= '0;
    end else if (stb.load) begin
      accQ  <= '0;
      mcQ   <= {{WIDTH{1'b0}}, opA};
      mpQ   <= opB;
      remQ  <= '0;
      quoQ  <= opA;
      dvsQ  <= opB;
      dendQ <= opA;
      leftQ <= BW'(WIDTH);
    end else if (stb.step) begin
      if (stb.isDiv) begin
        remQ  <= remN;
        quoQ  <= quoN;
        leftQ <= leftN;
      end else begin
        accQ <= accN;
        mcQ  <= mcN;
        mpQ  <= mpN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHi  <= '0;
      resLo  <= '0;
      divErr <= 1'b0;
    end else if (stb.finish) begin
      if (stb.isDiv) begin
        if (dvsQ == '0) begin
          resHi  <= dendQ;
          resLo  <= '1;
          divErr <= 1'b1;
        end else begin
          resHi  <= remN;
          resLo  <= quoN;
          divErr <= 1'b0;
        end
      end else begin
        resHi  <= accN[PW-1:WIDTH];
        resLo  <= accN[WIDTH-1:0];
        divErr <= 1'b0;
      end
    end
  end

  // R11: result words move only when a result is committed
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> ($stable(resHi) && $stable(resLo) && $stable(divErr)));

  // R6: a committed remainder is below its nonzero divisor
  assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && stb.isDiv && dvsQ != '0) |=> (resHi < $past(dvsQ)));

  // R7: the error flag always comes with an all-ones quotient
  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> (resLo == '1));

  // R5: a multiply commit never reports an error
  assert_mul_no_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !stb.isDiv) |=> !divErr);

endmodule

// File: rtl/mulDivSeq.sv
module mulDivSeq #(
  parameter int WIDTH   = 16,
  parameter int MUL_CYC = 5,
  parameter int DIV_CYC = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             abortIn,
  output logic             busyOut,
  output logic             bubbleOut,
  output logic             doneOut,
  output logic [WIDTH-1:0] resHi,
  output logic [WIDTH-1:0] resLo,
  output logic             divErr
);

  mds_pkg::mdsStrobe_t stb;

  mds_ctrl #(
    .MUL_CYC(MUL_CYC),
    .DIV_CYC(DIV_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .opDiv    (opDiv),
    .abortIn  (abortIn),
    .busyOut  (busyOut),
    .bubbleOut(bubbleOut),
    .doneOut  (doneOut),
    .stb      (stb)
  );

  mds_dp #(
    .WIDTH  (WIDTH),
    .MUL_CYC(MUL_CYC),
    .DIV_CYC(DIV_CYC)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .opA   (opA),
    .opB   (opB),
    .resHi (resHi),
    .resLo (resLo),
    .divErr(divErr)
  );

endmodule

// File: tb/tb_mulDivSeq.sv
module tb_mulDivSeq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startIn, opDiv, abortIn;
  logic [15:0] opA, opB;
  logic        busyOut, bubbleOut, doneOut, divErr;
  logic [15:0] resHi, resLo;

  int total = 0;
  int bad   = 0;

  logic [15:0] expHi = '0, expLo = '0;
  logic        expErr = 1'b0;

  always #5 clk = ~clk;

  mulDivSeq dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opDiv(opDiv),
    .opA(opA), .opB(opB), .abortIn(abortIn),
    .busyOut(busyOut), .bubbleOut(bubbleOut), .doneOut(doneOut),
    .resHi(resHi), .resLo(resLo), .divErr(divErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkResults(input string req);
    chk(req, "resHi", {16'b0, resHi}, {16'b0, expHi});
    chk(req, "resLo", {16'b0, resLo}, {16'b0, expLo});
    chk(req, "divErr", {31'b0, divErr}, {31'b0, expErr});
  endtask

  // R2/R3 timing with R4 bubbles and R5/R6/R7 results
  task automatic runOp(input logic isDiv, input logic [15:0] a, input logic [15:0] b,
                       input string resReq);
    int n;
    string tReq;
    logic [31:0] prod;
    n    = isDiv ? 10 : 5;
    tReq = isDiv ? "R3" : "R2";
    @(negedge clk);
    opDiv = isDiv; opA = a; opB = b; startIn = 1'b1;
    if (isDiv) begin
      if (b == 16'h0) begin
        expLo = 16'hFFFF; expHi = a; expErr = 1'b1;
      end else begin
        expLo = a / b; expHi = a % b; expErr = 1'b0;
      end
    end else begin
      prod = {16'b0, a} * {16'b0, b};
      expHi = prod[31:16]; expLo = prod[15:0]; expErr = 1'b0;
    end
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      startIn = 1'b0;
      chk(tReq, "busy during op", {31'b0, busyOut}, 32'd1);
      chk("R4", "bubble during op", {31'b0, bubbleOut}, 32'd1);
      chk(tReq, "no early done", {31'b0, doneOut}, 32'd0);
    end
    @(negedge clk);
    chk(tReq, "busy cleared", {31'b0, busyOut}, 32'd0);
    chk(tReq, "done pulse", {31'b0, doneOut}, 32'd1);
    chk("R4", "no bubble idle", {31'b0, bubbleOut}, 32'd0);
    chkResults(resReq);
    @(negedge clk);
    chk(tReq, "done single cycle", {31'b0, doneOut}, 32'd0);
    chkResults("R11");
  endtask

  // R8: abort after some busy cycles
  task automatic abortOp(input logic isDiv, input int runCycles);
    @(negedge clk);
    opDiv = isDiv; opA = 16'h1234; opB = 16'h0056; startIn = 1'b1;
    for (int i = 0; i < runCycles; i++) begin
      @(negedge clk);
      startIn = 1'b0;
    end
    abortIn = 1'b1;
    #1;
    chk("R4", "no bubble with abort", {31'b0, bubbleOut}, 32'd0);
    chk("R8", "still busy in abort cycle", {31'b0, busyOut}, 32'd1);
    @(negedge clk);
    abortIn = 1'b0;
    chk("R8", "busy cleared after abort", {31'b0, busyOut}, 32'd0);
    chk("R8", "no done after abort", {31'b0, doneOut}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8", "no late done", {31'b0, doneOut}, 32'd0);
      chk("R8", "stays idle", {31'b0, busyOut}, 32'd0);
    end
    chkResults("R8");
  endtask

  // R9: start strobe during a running divide
  task automatic startWhileBusy();
    logic [15:0] a, b;
    a = 16'd50000; b = 16'd123;
    @(negedge clk);
    opDiv = 1'b1; opA = a; opB = b; startIn = 1'b1;
    expLo = a / b; expHi = a % b; expErr = 1'b0;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      startIn = (i == 3);
      if (i == 3) begin
        opDiv = 1'b0; opA = 16'hFFFF; opB = 16'h0002;
      end else begin
        opA = 16'h0; opB = 16'h0;
      end
      chk("R9", "no done before divide end", {31'b0, doneOut}, 32'd0);
    end
    @(negedge clk);
    startIn = 1'b0;
    chk("R9", "done at divide time", {31'b0, doneOut}, 32'd1);
    chkResults("R9");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9", "no second operation", {31'b0, busyOut | doneOut}, 32'd0);
    end
    chkResults("R9");
  endtask

  // R10: abort while idle
  task automatic idleAbort();
    @(negedge clk);
    abortIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", "idle busy", {31'b0, busyOut}, 32'd0);
      chk("R10", "idle done", {31'b0, doneOut}, 32'd0);
      chk("R10", "idle bubble", {31'b0, bubbleOut}, 32'd0);
      chkResults("R10");
    end
    abortIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; startIn = 1'b0; opDiv = 1'b0; abortIn = 1'b0;
    opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busyOut}, 32'd0);
    chk("R1", "bubble", {31'b0, bubbleOut}, 32'd0);
    chk("R1", "done", {31'b0, doneOut}, 32'd0);
    chkResults("R1");

    runOp(1'b0, 16'd300, 16'd200, "R5");
    runOp(1'b0, 16'hFFFF, 16'hFFFF, "R5");
    runOp(1'b0, 16'h0000, 16'hBEEF, "R5");
    runOp(1'b0, 16'h8001, 16'h0003, "R5");
    runOp(1'b1, 16'd1000, 16'd7, "R6");
    runOp(1'b1, 16'hFFFF, 16'h0001, "R6");
    runOp(1'b1, 16'd5, 16'd9, "R6");
    runOp(1'b1, 16'hFFFF, 16'hFFFF, "R6");
    runOp(1'b1, 16'hABCD, 16'h0000, "R7");
    runOp(1'b0, 16'd7, 16'd6, "R5");

    abortOp(1'b0, 2);
    abortOp(1'b1, 5);
    abortOp(1'b1, 9);
    runOp(1'b1, 16'd40000, 16'd3, "R6");

    startWhileBusy();
    idleAbort();
    runOp(1'b0, 16'h1234, 16'h5678, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule